// File: doc/BRIEF.md
# ECC Page Status Aggregator

This block turns the per-step status left behind by a hardware BCH decoder into one page verdict. Once a page read has finished, a start pulse with the step count makes it fetch the packed 32-bit status words, one word per pair of steps, through a simple synchronous read port addressed by word number. From each word it takes two fail flags and two corrected-bit counts. It then keeps a saturating total of corrected bits, the largest count seen in any single step, and a count of words that reported an uncorrectable step.

Two status layouts are supported, and a layout input picks between them when the run starts. The narrow layout splits each 6-bit count into a low field and a separate high bit. The wide layout holds each 7-bit count in one field. When a word carries a fail flag for either of its steps, neither of its counts is added. The page result is the largest per-step count, or a failure code once any word has failed. A one-cycle done pulse marks the end of the run, and all results hold until the next start.

Top module: `ecc_status_agg`

## Requirements
- R1: After an accepted start with step count N, the block raises `rd_en_o` for exactly floor(N/2) consecutive cycles, with `rd_addr_o` going 0, 1, 2, ... one word per cycle. Read data is taken from `rd_data_i` one cycle after the matching `rd_en_o`.
- R2: With `layout_i`=0 (narrow), step A's fail flag is bit 2 and its count is {bit 27, bits 7:3}. Step B's fail flag is bit 15 and its count is {bit 29, bits 20:16}. All other bits are ignored.
- R3: With `layout_i`=1 (wide), step A's fail flag is bit 2 and its count is bits 9:3. Step B's fail flag is bit 18 and its count is bits 25:19. All other bits are ignored.
- R4: A word with either fail flag set adds one to `fail_cnt_o` and contributes nothing to `total_o` or `max_o`.
- R5: For every word without a fail flag, both counts are added to `total_o`, and `max_o` becomes the largest of its previous value and the two counts.
- R6: `result_o` is 8'hFF while `fail_cnt_o` is nonzero, and otherwise equals `max_o` zero-extended.
- R7: An odd N ignores the unpaired last step, so no word is read for it. N below 2 reads nothing and completes with all results zero.
- R8: `total_o` saturates at 16'hFFFF and never wraps.
- R9: `done_o` is high for exactly one cycle, floor(N/2)+1 clock edges after the edge that accepts start. The results stay stable afterwards until the next accepted start.
- R10: A start pulse while `busy_o` is high is ignored, and the run in progress finishes unchanged.
- R11: After reset, `busy_o`, `done_o` and `rd_en_o` are low, and the totals, maximum, fail count and result are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; also latches the step count and layout |
| steps_i | input | 10 | Number of ECC steps in the page |
| layout_i | input | 1 | Status layout: 0 narrow, 1 wide |
| rd_en_o | output | 1 | Status word read request |
| rd_addr_o | output | 9 | Status word index |
| rd_data_i | input | 32 | Status word, valid one cycle after the request |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| total_o | output | 16 | Saturating total of corrected bits |
| max_o | output | 7 | Largest per-step corrected count |
| fail_cnt_o | output | 16 | Number of words that reported a failure |
| result_o | output | 8 | Page result: maximum count, or 8'hFF on failure |

## Verification
The stimulus table runs clean pages in both layouts, with per-word counts that change from word to word. This tells apart a correct field split from a swapped or shifted one, and a true running maximum from a last-value register. Bench noise is placed in every bit that the active layout leaves unused, so a decoder that reads the wrong positions shows up in the totals. Pages with a failed step in slot A or slot B check that the whole pair is dropped and that the result changes to the failure code. Odd and tiny step counts, with failing garbage stored just past the last valid word, show whether the read count is computed correctly. Directed runs then cover saturation of the total, a start pulse in the middle of a run, and results holding after done.

// File: rtl/ecc_agg_pkg.sv
package ecc_agg_pkg;
  localparam int CNT_W = 7;

  typedef enum logic {
    LAYOUT_NARROW = 1'b0,
    LAYOUT_WIDE   = 1'b1
  } layout_e;

  typedef struct packed {
    logic             fail;
    logic [CNT_W-1:0] cnt;
  } step_stat_t;
endpackage

// File: rtl/ecc_agg_rst_sync.sv
module ecc_agg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/ecc_agg_field_extract.sv
module ecc_agg_field_extract
  import ecc_agg_pkg::*;
#(
  parameter int SLOT   = 0,
  parameter int DATA_W = 32
) (
  input  layout_e          layout_i,
  input  logic [DATA_W-1:0] word_i,
  output step_stat_t       stat_o
);
  // Slot 0 is the lower step of the pair, slot 1 the upper one.
  if (SLOT == 0) begin : g_slot_lo
    always_comb begin
      stat_o.fail = word_i[2];
      if (layout_i == LAYOUT_WIDE) stat_o.cnt = word_i[9:3];
      else                         stat_o.cnt = {1'b0, word_i[27], word_i[7:3]};
    end
  end else begin : g_slot_hi
    always_comb begin
      if (layout_i == LAYOUT_WIDE) begin
        stat_o.fail = word_i[18];
        stat_o.cnt  = word_i[25:19];
      end else begin
        stat_o.fail = word_i[15];
        stat_o.cnt  = {1'b0, word_i[29], word_i[20:16]};
      end
    end
  end
endmodule

// File: rtl/ecc_agg_sequencer.sv
module ecc_agg_sequencer #(
  parameter int STEP_W = 10,
  localparam int ADDR_W = STEP_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [STEP_W-1:0] steps_i,
  output logic              accept_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              vld_o,
  output logic              last_o,
  output logic              empty_o,
  output logic              busy_o
);
  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic [ADDR_W-1:0] words_q, words_d;
  logic [ADDR_W-1:0] words_in;
  logic              issue_last;
  logic              vld_q, last_q, empty_q;
  logic              seq_en;

  // Word count drops the unpaired odd step.
  assign words_in   = steps_i[STEP_W-1:1];
  assign busy_o     = (state_q == ST_RUN) | vld_q | empty_q;
  assign accept_o   = start_i & ~busy_o;
  assign rd_en_o    = (state_q == ST_RUN);
  assign rd_addr_o  = cnt_q;
  assign issue_last = rd_en_o & (cnt_q == words_q - 1'b1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    words_d = words_q;
    if (accept_o) begin
      words_d = words_in;
      cnt_d   = '0;
      state_d = (words_in != '0) ? ST_RUN : ST_IDLE;
    end else if (state_q == ST_RUN) begin
      if (issue_last) state_d = ST_IDLE;
      else            cnt_d   = cnt_q + 1'b1;
    end
  end

  assign seq_en = accept_o | (state_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      words_q <= '0;
    end else if (seq_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      words_q <= words_d;
    end
  end

  // Read data returns one cycle after the request.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      last_q  <= 1'b0;
      empty_q <= 1'b0;
    end else begin
      vld_q   <= rd_en_o;
      last_q  <= issue_last;
      empty_q <= accept_o & (words_in == '0);
    end
  end

  assign vld_o   = vld_q;
  assign last_o  = last_q;
  assign empty_o = empty_q;
endmodule

// File: rtl/ecc_agg_accum.sv
module ecc_agg_accum
  import ecc_agg_pkg::*;
#(
  parameter int SUM_W  = 16,
  parameter int FCNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              vld_i,
  input  logic              last_i,
  input  logic              empty_i,
  input  step_stat_t        stat_a_i,
  input  step_stat_t        stat_b_i,
  output logic [SUM_W-1:0]  total_o,
  output logic [CNT_W-1:0]  max_o,
  output logic [FCNT_W-1:0] fail_cnt_o,
  output logic              done_o
);
  logic [SUM_W-1:0]  total_q, total_d;
  logic [CNT_W-1:0]  max_q, max_d;
  logic [FCNT_W-1:0] fail_q, fail_d;
  logic              done_q;
  logic              pair_fail;
  logic [SUM_W:0]    sum_w;
  logic              acc_en;

  assign pair_fail = stat_a_i.fail | stat_b_i.fail;
  assign sum_w     = {1'b0, total_q} + (SUM_W+1)'(stat_a_i.cnt) + (SUM_W+1)'(stat_b_i.cnt);
  assign acc_en    = clear_i | vld_i;

  always_comb begin
    total_d = total_q;
    max_d   = max_q;
    fail_d  = fail_q;
    if (clear_i) begin
      total_d = '0;
      max_d   = '0;
      fail_d  = '0;
    end else if (vld_i) begin
      if (pair_fail) begin
        if (fail_q != '1) fail_d = fail_q + 1'b1;
      end else begin
        total_d = sum_w[SUM_W] ? '1 : sum_w[SUM_W-1:0];
        if (stat_a_i.cnt > max_d) max_d = stat_a_i.cnt;
        if (stat_b_i.cnt > max_d) max_d = stat_b_i.cnt;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_q <= '0;
      max_q   <= '0;
      fail_q  <= '0;
    end else if (acc_en) begin
      total_q <= total_d;
      max_q   <= max_d;
      fail_q  <= fail_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= (vld_i & last_i) | empty_i;
  end

  assign total_o    = total_q;
  assign max_o      = max_q;
  assign fail_cnt_o = fail_q;
  assign done_o     = done_q;
endmodule

// File: rtl/ecc_status_agg.sv
module ecc_status_agg
  import ecc_agg_pkg::*;
#(
  parameter int STEP_W = 10,
  parameter int DATA_W = 32,
  parameter int SUM_W  = 16,
  parameter int FCNT_W = 16,
  localparam int ADDR_W = STEP_W - 1,
  localparam int RES_W  = CNT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [STEP_W-1:0] steps_i,
  input  logic              layout_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [SUM_W-1:0]  total_o,
  output logic [CNT_W-1:0]  max_o,
  output logic [FCNT_W-1:0] fail_cnt_o,
  output logic [RES_W-1:0]  result_o
);
  logic       rst_n_int;
  logic       accept, vld, last, empty;
  layout_e    layout_q;
  step_stat_t stat_pair [2];

  ecc_agg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_int)
  );

  ecc_agg_sequencer #(.STEP_W(STEP_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .start_i   (start_i),
    .steps_i   (steps_i),
    .accept_o  (accept),
    .rd_en_o   (rd_en_o),
    .rd_addr_o (rd_addr_o),
    .vld_o     (vld),
    .last_o    (last),
    .empty_o   (empty),
    .busy_o    (busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int)  layout_q <= LAYOUT_NARROW;
    else if (accept) layout_q <= layout_e'(layout_i);
  end

  for (genvar s = 0; s < 2; s++) begin : g_slot
    ecc_agg_field_extract #(.SLOT(s), .DATA_W(DATA_W)) u_ext (
      .layout_i (layout_q),
      .word_i   (rd_data_i),
      .stat_o   (stat_pair[s])
    );
  end

  ecc_agg_accum #(.SUM_W(SUM_W), .FCNT_W(FCNT_W)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .clear_i    (accept),
    .vld_i      (vld),
    .last_i     (last),
    .empty_i    (empty),
    .stat_a_i   (stat_pair[0]),
    .stat_b_i   (stat_pair[1]),
    .total_o    (total_o),
    .max_o      (max_o),
    .fail_cnt_o (fail_cnt_o),
    .done_o     (done_o)
  );

  assign result_o = (fail_cnt_o != '0) ? '1 : {1'b0, max_o};
endmodule

// File: rtl/ecc_status_agg_chk.sv
module ecc_status_agg_chk #(
  parameter int ADDR_W = 9,
  parameter int SUM_W  = 16,
  parameter int FCNT_W = 16,
  parameter int CNT_W  = 7,
  parameter int RES_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [SUM_W-1:0]  total_o,
  input logic [CNT_W-1:0]  max_o,
  input logic [FCNT_W-1:0] fail_cnt_o,
  input logic [RES_W-1:0]  result_o
);
  assert_addr_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o && $past(rd_en_o) |-> rd_addr_o == ADDR_W'($past(rd_addr_o) + 1'b1));

  assert_fail_monotone_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) && busy_o |-> fail_cnt_o >= $past(fail_cnt_o));

  assert_max_le_total_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {{(SUM_W-CNT_W){1'b0}}, max_o} <= total_o);

  assert_fail_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_cnt_o != '0 |-> result_o == '1);

  assert_pass_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_cnt_o == '0 |-> result_o != '1);

  assert_total_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) && busy_o |-> total_o >= $past(total_o));

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_hold_after_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(done_o) && !busy_o |-> $stable(total_o) && $stable(fail_cnt_o));

  assert_idle_no_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rd_en_o);
endmodule

bind ecc_status_agg ecc_status_agg_chk #(
  .ADDR_W (ADDR_W),
  .SUM_W  (SUM_W),
  .FCNT_W (FCNT_W),
  .CNT_W  (ecc_agg_pkg::CNT_W),
  .RES_W  (RES_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_en_o    (rd_en_o),
  .rd_addr_o  (rd_addr_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .total_o    (total_o),
  .max_o      (max_o),
  .fail_cnt_o (fail_cnt_o),
  .result_o   (result_o)
);

// File: tb/ecc_status_agg_tb.sv
`timescale 1ns/1ps
module ecc_status_agg_tb;
  localparam int STEP_W = 10;
  localparam int ADDR_W = 9;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [STEP_W-1:0] steps;
  logic              layout;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [31:0]       rd_data;
  logic              busy, done;
  logic [15:0]       total;
  logic [6:0]        max_c;
  logic [15:0]       fail_cnt;
  logic [7:0]        result;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ecc_status_agg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .steps_i(steps), .layout_i(layout),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data), .busy_o(busy),
    .done_o(done), .total_o(total), .max_o(max_c), .fail_cnt_o(fail_cnt), .result_o(result)
  );

  logic [31:0] mem [0:511];
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  int rd_cnt;
  int exp_addr;
  int addr_err;
  always @(posedge clk) begin
    if (rst_n && rd_en) begin
      if (rd_addr != ADDR_W'(exp_addr)) addr_err++;
      exp_addr++;
      rd_cnt++;
    end
  end

  typedef struct packed {
    logic       lay;
    logic [9:0] nsteps;
    logic [6:0] a;
    logic [6:0] b;
    logic [9:0] failk;
    logic       fslot;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b0, 10'd8,  7'd1,   7'd2,  10'h3FF, 1'b0},
    '{1'b1, 10'd8,  7'd100, 7'd7,  10'h3FF, 1'b0},
    '{1'b0, 10'd9,  7'd60,  7'd33, 10'h3FF, 1'b0},
    '{1'b1, 10'd12, 7'd5,   7'd5,  10'd2,   1'b1},
    '{1'b0, 10'd6,  7'd10,  7'd63, 10'd0,   1'b0},
    '{1'b1, 10'd2,  7'd127, 7'd0,  10'h3FF, 1'b0},
    '{1'b1, 10'd1,  7'd9,   7'd9,  10'h3FF, 1'b0},
    '{1'b0, 10'd20, 7'd31,  7'd32, 10'h3FF, 1'b0}
  };

  // Status word builder from the field positions in R2 and R3.
  function automatic logic [31:0] enc(input logic lay, input int ca, input int cb,
                                      input logic fa, input logic fb);
    logic [31:0] w;
    if (!lay) begin
      w = 32'hD7E07F03;
      w[7:3] = ca[4:0]; w[27] = ca[5];
      w[20:16] = cb[4:0]; w[29] = cb[5];
      w[2] = fa; w[15] = fb;
    end else begin
      w = 32'hFC03FC03;
      w[9:3] = ca[6:0]; w[25:19] = cb[6:0];
      w[2] = fa; w[18] = fb;
    end
    return w;
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic start_run(input logic lay, input int n);
    @(negedge clk);
    rd_cnt = 0; exp_addr = 0; addr_err = 0;
    layout = lay; steps = STEP_W'(n); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    do begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end while (!done && cyc < 5000);
  endtask

  task automatic run_vec(input vec_t v, input string tag);
    int w, mask, ca, cb, etot, emax, efail, cyc;
    logic fa, fb;
    w = int'(v.nsteps) / 2;
    mask = v.lay ? 127 : 63;
    etot = 0; emax = 0; efail = 0;
    for (int k = 0; k < 512; k++) begin
      ca = (int'(v.a) + 3*k) & mask;
      cb = (int'(v.b) + 5*k) & mask;
      fa = (k == int'(v.failk)) && !v.fslot;
      fb = (k == int'(v.failk)) &&  v.fslot;
      if (k < w) begin
        mem[k] = enc(v.lay, ca, cb, fa, fb);
        if (fa || fb) efail++;
        else begin
          etot = etot + ca + cb;
          if (etot > 65535) etot = 65535;
          if (ca > emax) emax = ca;
          if (cb > emax) emax = cb;
        end
      end else begin
        mem[k] = enc(v.lay, mask, mask, 1'b1, 1'b1);
      end
    end
    start_run(v.lay, int'(v.nsteps));
    wait_done(cyc);
    chk(tag, "total R5", total, etot);
    chk(tag, "max R5", max_c, emax);
    chk(tag, "fail count R4", fail_cnt, efail);
    chk(tag, "result R6", result, efail != 0 ? 255 : emax);
    chk(tag, "done latency R9", cyc, w + 1);
    chk(tag, "read count R1", rd_cnt, w);
    chk(tag, "read order R1", addr_err, 0);
    @(negedge clk);
    chk(tag, "done one cycle R9", done, 0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] hold_tot;
    start = 1'b0; steps = '0; layout = 1'b0; rst_n = 1'b0;
    rd_cnt = 0; exp_addr = 0; addr_err = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R11", "busy after reset", busy, 0);
    chk("R11", "done after reset", done, 0);
    chk("R11", "rd_en after reset", rd_en, 0);
    chk("R11", "total after reset", total, 0);
    chk("R11", "result after reset", result, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      string tag;
      if (VECS[i].nsteps < 2 || VECS[i].nsteps[0]) tag = "R7";
      else if (VECS[i].lay) tag = "R3";
      else tag = "R2";
      run_vec(VECS[i], tag);
    end

    // R8: saturation of the total
    for (int k = 0; k < 512; k++) mem[k] = enc(1'b1, 127, 127, 1'b0, 1'b0);
    start_run(1'b1, 600);
    wait_done(cyc);
    chk("R8", "saturated total", total, 65535);
    chk("R8", "max under saturation", max_c, 127);
    chk("R8", "result under saturation", result, 127);

    // R9: results hold after done
    hold_tot = total;
    repeat (3) @(negedge clk);
    chk("R9", "total held", total, hold_tot);
    chk("R9", "done stays low", done, 0);

    // R10: start while busy is ignored
    for (int k = 0; k < 512; k++)
      mem[k] = (k < 4) ? enc(1'b0, 2*k + 1, 2*k + 2, 1'b0, 1'b0)
                       : enc(1'b0, 63, 63, 1'b0, 1'b0);
    start_run(1'b0, 8);
    @(negedge clk);
    start = 1'b1; steps = 10'd40; layout = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    chk("R10", "total after ignored start", total, 36);
    chk("R10", "max after ignored start", max_c, 8);
    chk("R10", "reads after ignored start", rd_cnt, 4);
    @(negedge clk);
    chk("R10", "idle after run", busy, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule